// File: doc/BRIEF.md
# Eight-bit event timer with selectable prescaler

This block is an 8-bit up-counter that advances on one of two tick sources: a one-clock strobe that marks each instruction cycle, or edges on an asynchronous external clock pin. For the pin source, a polarity control picks whether rising or falling transitions count. The pin is brought into the system clock domain through a two-flop synchroniser, and edges are detected on the synchronised copy.

A power-of-two prescaler can sit between the tick source and the counter. When it is assigned, the counter advances once every 2 to 256 qualified ticks, and the divide is set by a 3-bit ratio field. When it is bypassed, every qualified tick advances the counter. Software loads the counter through a data-plus-strobe write port. Any load clears the assigned prescaler and blanks counting for the next two instruction cycles. A one-cycle overflow pulse marks each wrap from 0xFF to 0x00.

Top module: `cycle_event_timer`

## Requirements
- R1: While rst is high at a clock edge, count_q becomes 0x00 and ovf_pulse becomes 0.
- R2: A clock edge with wr_en high loads wr_data into count_q. The value is visible after that edge, and the load takes priority over any increment in the same cycle.
- R3: After a load, the qualified ticks that arrive while the next two cyc_tick pulses occur are discarded. The first qualified tick after those two pulses counts again.
- R4: With src_ext = 0 the counter advances only on cyc_tick pulses, and edges on ext_clk_in have no effect. With src_ext = 1 the counter advances only on ext_clk_in edges, and cyc_tick pulses have no effect.
- R5: With src_ext = 1, edge_fall = 0 counts 0-to-1 transitions of ext_clk_in and edge_fall = 1 counts 1-to-0 transitions. The resulting increment appears at the third rising clock edge after the pin change.
- R6: With pre_bypass = 1, every qualified tick adds exactly one to count_q, whatever the value of pre_ratio.
- R7: With pre_bypass = 0, count_q advances once per 2^(pre_ratio+1) qualified ticks. Code 000 divides by 2, code 010 divides by 8 and code 111 divides by 256.
- R8: A load while pre_bypass = 0 clears the prescaler, so a full divide period of new ticks is needed before the next increment.
- R9: ovf_pulse is high for exactly one clock cycle, in the cycle in which count_q shows 0x00 after an increment from 0xFF. A load never raises it.
- R10: Without a load, count_q changes by at most +1 (mod 256) per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-clock strobe for each instruction cycle |
| ext_clk_in | input | 1 | Asynchronous external count clock |
| src_ext | input | 1 | Tick source: 0 = instruction cycle, 1 = external pin |
| edge_fall | input | 1 | Pin polarity: 0 = rising edges, 1 = falling edges |
| pre_bypass | input | 1 | 0 = prescaler in front of the counter, 1 = bypassed |
| pre_ratio | input | 3 | Prescaler divide code: divide by 2^(code+1) |
| wr_en | input | 1 | Load strobe for the counter |
| wr_data | input | 8 | Value to load |
| count_q | output | 8 | Current count |
| ovf_pulse | output | 1 | One-cycle pulse on wrap from 0xFF to 0x00 |

## Verification
The assertions check on every cycle that a load lands exactly, that the count moves by at most one step without a load, and that it holds still while the post-load blanking window is open. They also check that the overflow pulse appears only at a true wrap, that the prescaler is empty after a clear, and that it only emits on an input tick. What the assertions cannot show is the count reached after a given number of ticks. The bench scenarios demonstrate the divide ratios, the polarity and source selection, the three-edge synchroniser latency, and the missing increment that proves the prescaler was cleared.

// File: rtl/cet_pkg.sv
package cet_pkg;
    localparam int CNT_W    = 8;
    localparam int RATIO_W  = 3;
    localparam int PRE_W    = 2 ** RATIO_W;
    localparam int PRE_DW   = PRE_W + 1;
    localparam int HOLD_CYC = 2;

    typedef enum logic {
        SRC_CYCLE = 1'b0,
        SRC_PIN   = 1'b1
    } src_sel_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    typedef struct packed {
        src_sel_e             src;
        edge_sel_e            pol;
        logic                 pre_bypass;
        logic [RATIO_W-1:0]   ratio;
    } tmr_ctrl_t;

    typedef struct packed {
        logic               load;
        logic [CNT_W-1:0]   value;
    } tmr_wr_t;

    // last prescaler state before the wrap for a given ratio code
    function automatic logic [PRE_W-1:0] pre_terminal(input logic [RATIO_W-1:0] r);
        logic [PRE_DW-1:0] div;
        div = PRE_DW'(2) << r;
        return PRE_W'(div - PRE_DW'(1));
    endfunction
endpackage

// File: rtl/cet_edge_sync.sv
module cet_edge_sync
    import cet_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  edge_sel_e pol_i,
    output logic      edge_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise, fall;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= pin_i;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sync_q[s] <= 1'b0;
            else     sync_q[s] <= sync_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[MSB];
    end

    assign rise   = sync_q[MSB] & ~last_q;
    assign fall   = ~sync_q[MSB] & last_q;
    assign edge_o = (pol_i == EDGE_FALL) ? fall : rise;

    // R5
    rise_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
    // R5
    fall_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
endmodule

// File: rtl/cet_holdoff.sv
module cet_holdoff
    import cet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic cyc_tick_i,
    input  logic tick_i,
    output logic tick_o,
    output logic busy_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (load_i)
            hold_q <= HW'(HOLD_CYC);
        else if (cyc_tick_i && hold_q != '0)
            hold_q <= hold_q - HW'(1);
    end

    assign busy_o = (hold_q != '0);
    assign tick_o = tick_i & ~busy_o & ~load_i;

    // R3
    hold_arm_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> busy_o);
    // R3
    hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !cyc_tick_i) |=> hold_q == $past(hold_q));
endmodule

// File: rtl/cet_prescaler.sv
module cet_prescaler
    import cet_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic               bypass_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               tick_i,
    output logic               inc_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] term;
    logic             wrap;

    assign term = pre_terminal(ratio_i);
    // >= keeps the wrap alive if the ratio shrinks mid-period
    assign wrap = tick_i && (pre_q >= term);

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            pre_q <= '0;
        else if (tick_i && !bypass_i)
            pre_q <= wrap ? '0 : pre_q + PRE_W'(1);
    end

    assign inc_o = bypass_i ? tick_i : wrap;

    // R8
    pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> pre_q == '0);
    // R7
    pre_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        inc_o |-> tick_i);
endmodule

// File: rtl/cet_count_core.sv
module cet_count_core
    import cet_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tmr_wr_t          wr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (wr_i.load) begin
                cnt_q <= wr_i.value;
            end else if (inc_i) begin
                cnt_q <= cnt_q + CNT_W'(1);
                ovf_q <= (cnt_q == CNT_MAX);
            end
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R2
    load_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i.load |=> cnt_q == $past(wr_i.value));
    // R10
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i.load |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));
    // R9
    wrap_only_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> (cnt_q == '0) && ($past(cnt_q) == CNT_MAX) && !$past(wr_i.load));
    // R9
    ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> !ovf_q);
endmodule

// File: rtl/cycle_event_timer.sv
module cycle_event_timer
    import cet_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cyc_tick,
    input  logic               ext_clk_in,
    input  logic               src_ext,
    input  logic               edge_fall,
    input  logic               pre_bypass,
    input  logic [RATIO_W-1:0] pre_ratio,
    input  logic               wr_en,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   count_q,
    output logic               ovf_pulse
);
    tmr_ctrl_t ctrl;
    tmr_wr_t   wr;
    logic      pin_edge;
    logic      raw_tick;
    logic      gated_tick;
    logic      hold_busy;
    logic      cnt_inc;

    assign ctrl.src        = src_ext   ? SRC_PIN   : SRC_CYCLE;
    assign ctrl.pol        = edge_fall ? EDGE_FALL : EDGE_RISE;
    assign ctrl.pre_bypass = pre_bypass;
    assign ctrl.ratio      = pre_ratio;
    assign wr.load         = wr_en;
    assign wr.value        = wr_data;

    cet_edge_sync #(.SYNC_STAGES(2)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ext_clk_in),
        .pol_i  (ctrl.pol),
        .edge_o (pin_edge)
    );

    assign raw_tick = (ctrl.src == SRC_PIN) ? pin_edge : cyc_tick;

    cet_holdoff hold_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wr.load),
        .cyc_tick_i (cyc_tick),
        .tick_i     (raw_tick),
        .tick_o     (gated_tick),
        .busy_o     (hold_busy)
    );

    cet_prescaler pre_i (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (wr.load & ~ctrl.pre_bypass),
        .bypass_i (ctrl.pre_bypass),
        .ratio_i  (ctrl.ratio),
        .tick_i   (gated_tick),
        .inc_o    (cnt_inc)
    );

    cet_count_core core_i (
        .clk   (clk),
        .rst   (rst),
        .wr_i  (wr),
        .inc_i (cnt_inc),
        .cnt_o (count_q),
        .ovf_o (ovf_pulse)
    );

    // R3
    blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_busy && !wr_en) |=> count_q == $past(count_q));
    // R6
    bypass_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_bypass && gated_tick && !wr_en) |=> count_q == $past(count_q) + CNT_W'(1));
endmodule

// File: tb/cycle_event_timer_tb_top.sv
module cycle_event_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_tick = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic       src_ext = 1'b0;
    logic       edge_fall = 1'b0;
    logic       pre_bypass = 1'b1;
    logic [2:0] pre_ratio = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] count_q;
    logic       ovf_pulse;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    cycle_event_timer dut_i (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .ext_clk_in(ext_clk_in),
        .src_ext(src_ext), .edge_fall(edge_fall), .pre_bypass(pre_bypass),
        .pre_ratio(pre_ratio), .wr_en(wr_en), .wr_data(wr_data),
        .count_q(count_q), .ovf_pulse(ovf_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        cyc_tick = 1'b1;
        repeat (n) @(negedge clk);
        cyc_tick = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        ext_clk_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 count after reset", count_q, 0);
        chk("R1 ovf after reset", ovf_pulse, 0);
    endtask

    task automatic t_write;
        src_ext = 1'b0; pre_bypass = 1'b1;
        do_write(8'h5A);
        chk("R2 load value", count_q, 8'h5A);
        cyc_tick = 1'b1;
        do_write(8'h33);
        cyc_tick = 1'b0;
        chk("R2 load beats tick", count_q, 8'h33);
    endtask

    task automatic t_holdoff;
        do_write(8'd10);
        ticks(2);
        chk("R3 two blanked ticks", count_q, 10);
        ticks(1);
        chk("R3 third tick counts", count_q, 11);
        ticks(3);
        chk("R6 bypass counts each tick", count_q, 14);
        pre_ratio = 3'd7;
        ticks(3);
        chk("R6 ratio ignored in bypass", count_q, 17);
        pre_ratio = 3'd0;
    endtask

    task automatic t_source;
        src_ext = 1'b0;
        set_pin(1'b1); set_pin(1'b0); set_pin(1'b1); set_pin(1'b0);
        chk("R4 pin ignored on cycle source", count_q, 17);
        src_ext = 1'b1;
        ticks(4);
        chk("R4 cycle tick ignored on pin source", count_q, 17);
    endtask

    task automatic t_edges;
        src_ext = 1'b1; edge_fall = 1'b0;
        do_write(8'd0);
        ticks(2);
        set_pin(1'b1); set_pin(1'b0);
        set_pin(1'b1); set_pin(1'b0);
        chk("R5 rising edges counted", count_q, 2);
        ext_clk_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 not yet through synchroniser", count_q, 2);
        @(negedge clk);
        chk("R5 third edge latency", count_q, 3);
        @(negedge clk);
        edge_fall = 1'b1;
        set_pin(1'b0);
        chk("R5 falling edge counted", count_q, 4);
        set_pin(1'b1);
        chk("R5 rising edge ignored in falling mode", count_q, 4);
        set_pin(1'b0);
        edge_fall = 1'b0;
        src_ext = 1'b0;
    endtask

    task automatic t_prescale;
        pre_bypass = 1'b0; pre_ratio = 3'd0;
        do_write(8'd0); ticks(2);
        ticks(7);
        chk("R7 divide by 2", count_q, 3);
        pre_ratio = 3'd2;
        do_write(8'd0); ticks(2);
        ticks(15);
        chk("R7 divide by 8 before wrap", count_q, 1);
        ticks(1);
        chk("R7 divide by 8 at wrap", count_q, 2);
        pre_ratio = 3'd7;
        do_write(8'd0); ticks(2);
        ticks(255);
        chk("R7 divide by 256 before wrap", count_q, 0);
        ticks(1);
        chk("R7 divide by 256 at wrap", count_q, 1);
    endtask

    task automatic t_preclr;
        pre_bypass = 1'b0; pre_ratio = 3'd0;
        do_write(8'd0); ticks(2);
        ticks(1);
        chk("R8 half period pending", count_q, 0);
        do_write(8'h20); ticks(2);
        ticks(1);
        chk("R8 prescaler cleared by load", count_q, 8'h20);
        ticks(1);
        chk("R8 full period after clear", count_q, 8'h21);
    endtask

    task automatic t_overflow;
        pre_bypass = 1'b1;
        do_write(8'hFE); ticks(2);
        ticks(1);
        chk("R9 no ovf at 0xFF", ovf_pulse, 0);
        ticks(1);
        chk("R9 wrap to zero", count_q, 0);
        chk("R9 ovf raised on wrap", ovf_pulse, 1);
        @(negedge clk);
        chk("R9 ovf one cycle only", ovf_pulse, 0);
        do_write(8'hFF);
        do_write(8'h00);
        chk("R9 load gives no ovf", ovf_pulse, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_holdoff();
        t_source();
        t_edges();
        t_prescale();
        t_preclr();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule